// File: doc/BRIEF.md
# GPIO Interrupt Detector Bank

This block watches a bank of general-purpose input pads and turns level or edge events on them into interrupt requests. Every pin owns a configuration register and a status register. The configuration register holds a mask bit, a polarity bit, a detection field, a capture gate and a 3-bit routing target. Each pad is passed through a two-flop synchronizer. The block then compares the current synchronized sample with the previous one. When the configured condition is met, it latches a sticky status bit. Software clears that bit by writing to the status register.

The status bits of unmasked pins are merged per target into a small vector of parent interrupt lines. Output `irq_o[k]` collects every pin whose target field equals k. The parameter `DET_W` picks one of two detection encodings. When it is 2, a 2-bit field gives level, rising, falling and native both-edge detection. When it is 1, a single bit chooses between level and edge, and the polarity bit picks which edge or level. The parameter `ACK_VAL` picks whether writing 1 or writing 0 to the status bit performs the clear. The bus is a simple single-cycle register port. Writes take effect at the clock edge, and reads are combinational.

Register index = {pin, sel}. sel=0 selects the configuration register and sel=1 selects the status register.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every configuration register reads 0x00 (mask off, polarity 0, detection 0 = active-low level, capture gate off, target 0), every status bit is 0 and `irq_o` is all zero.
- R2: Status register bit 1 returns the synchronized pad value. A pad change made before clock edge k is visible after edge k+1, and not after edge k alone.
- R3: In level mode (detection value 0), status is set on every clock where the synchronized input equals the polarity bit (1 = active high, 0 = active low). This holds in both variants.
- R4: With DET_W=2, detection value 1 sets status on a rising edge, 2 on a falling edge and 3 on either edge. In these modes the status bit is set two clock edges after the pad change is seen, i.e. after the third edge.
- R5: With DET_W=1, detection bit (register bit 2) = 1 selects edge mode, where polarity 1 means rising and polarity 0 means falling; the other edge sets nothing. Register bit 3 is not stored in this variant.
- R6: A write to the status register whose bit 0 equals ACK_VAL clears the status bit. A write with the opposite bit 0 value leaves the status bit unchanged.
- R7: When a detection event and a clearing write fall in the same cycle, the status bit ends up set.
- R8: With the capture gate (bit 4) at 0, status never becomes set. Raising the gate while the pad is high appears as a rising edge and sets status in a rising or both-edge mode one edge later.
- R9: Status latches regardless of the mask bit (bit 0). The mask bit only decides whether a set status bit drives its parent output, and setting the mask on a pending pin raises the output at once.
- R10: `irq_o[k]` is high exactly when some pin has mask=1, status=1 and target field (bits 7:5) equal to k. A target of NUM_OUT or above drives no output.
- R11: In level mode, a clearing write while the level is still active has no lasting effect, because status is set again on that same edge.
- R12: The configuration register layout is bit 0 mask, bit 1 polarity, bits 3:2 detection, bit 4 capture gate, bits 7:5 target. It reads back as written, with bit 3 forced to 0 when DET_W=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pad_i | input | NUM_PINS | Asynchronous pad inputs |
| reg_addr | input | AW | Register index {pin, sel} |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data |
| irq_o | output | NUM_OUT | Parent interrupt line per target |

## Verification
The hard overlap is a status clear arriving in the very cycle a new qualifying edge reaches the detector. A clear that wins that race loses an interrupt. The bench counts the synchronizer and history registers so that its clearing write lands exactly on the edge where the rising transition is detected, and it expects the status bit to remain set. The level-mode case, where a clear meets a still-active level, and the gate-raise spurious edge are provoked the same way and judged against a bench model that is updated on each clock.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int CFG_W = 8;
  localparam int TGT_W = 3;

  // Bit layout of a pin configuration register, MSB first.
  typedef struct packed {
    logic [TGT_W-1:0] tgt;     // 7:5 routing target
    logic             raw_en;  // 4   capture gate
    logic [1:0]       det;     // 3:2 detection field
    logic             pol;     // 1   polarity
    logic             en;      // 0   mask (1 = forward)
  } irq_cfg_t;

  // Detection decision for one pin on one clock.
  function automatic logic detect_hit(input int det_w, input logic [1:0] det,
                                      input logic pol, input logic cur,
                                      input logic prv);
    logic rise, fall, lvl;
    rise = cur & ~prv;
    fall = ~cur & prv;
    lvl  = pol ? cur : ~cur;
    if (det_w == 2) begin
      case (det)
        2'd0:    detect_hit = lvl;
        2'd1:    detect_hit = rise;
        2'd2:    detect_hit = fall;
        default: detect_hit = rise | fall;
      endcase
    end else begin
      detect_hit = det[0] ? (pol ? rise : fall) : lvl;
    end
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
  import gpio_irq_pkg::*;
#(
  parameter int DET_W   = 2,
  parameter bit ACK_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pad_i,
  input  logic             cfg_we,
  input  logic             sts_we,
  input  logic [CFG_W-1:0] wdata,
  output irq_cfg_t         cfg_o,
  output logic             status_o,
  output logic             in_o
);
  localparam logic [1:0] DET_MASK = (DET_W == 2) ? 2'b11 : 2'b01;

  irq_cfg_t cfg_q, cfg_new;
  logic     in_s, gated, gated_q, hit, ack, status_q;

  gpio_irq_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pad_i), .q_o(in_s)
  );

  // Named events for the checks below.
  assign gated = in_s & cfg_q.raw_en;
  assign hit   = cfg_q.raw_en &
                 detect_hit(DET_W, cfg_q.det, cfg_q.pol, gated, gated_q);
  assign ack   = sts_we & (wdata[0] == ACK_VAL);

  always_comb begin
    cfg_new     = irq_cfg_t'(wdata);
    cfg_new.det = cfg_new.det & DET_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      gated_q  <= 1'b0;
      status_q <= 1'b0;
    end else begin
      gated_q <= gated;
      if (cfg_we) cfg_q <= cfg_new;
      if (hit)      status_q <= 1'b1;   // detection outranks the clear
      else if (ack) status_q <= 1'b0;
    end
  end

  assign cfg_o    = cfg_q;
  assign status_o = status_q;
  assign in_o     = in_s;

  assert_hit_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> status_q);
  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !hit) |=> !status_q);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !ack) |=> status_q);
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ack) |=> status_q);
  assert_gate_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_q && !cfg_q.raw_en) |=> !status_q);
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int NUM_OUT  = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_PINS-1:0]             en_i,
  input  logic [NUM_PINS-1:0]             sts_i,
  input  logic [NUM_PINS-1:0][TGT_W-1:0]  tgt_i,
  output logic [NUM_OUT-1:0]              irq_o
);
  logic [NUM_PINS-1:0] live;
  assign live = en_i & sts_i;

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic [NUM_PINS-1:0] sel_v;
    always_comb begin
      for (int i = 0; i < NUM_PINS; i++)
        sel_v[i] = live[i] && (tgt_i[i] == TGT_W'(o));
    end
    assign irq_o[o] = |sel_v;
  end

  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (live == '0) |-> (irq_o == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int NUM_OUT  = 2,
  parameter int DET_W    = 2,
  parameter bit ACK_VAL  = 1'b1,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int AW      = PIN_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pad_i,
  input  logic [AW-1:0]       reg_addr,
  input  logic                reg_we,
  input  logic [CFG_W-1:0]    reg_wdata,
  output logic [CFG_W-1:0]    reg_rdata,
  output logic [NUM_OUT-1:0]  irq_o
);
  logic [PIN_W-1:0] pin_sel;
  logic             sts_sel;
  assign pin_sel = reg_addr[AW-1:1];
  assign sts_sel = reg_addr[0];

  irq_cfg_t                       cfg_w [NUM_PINS];
  logic [NUM_PINS-1:0]            sts_w, in_w, en_w;
  logic [NUM_PINS-1:0][TGT_W-1:0] tgt_w;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic hit_pin;
    assign hit_pin = (pin_sel == PIN_W'(i));
    gpio_irq_pin #(.DET_W(DET_W), .ACK_VAL(ACK_VAL)) u_pin (
      .clk(clk), .rst_n(rst_n), .pad_i(pad_i[i]),
      .cfg_we(reg_we & hit_pin & ~sts_sel),
      .sts_we(reg_we & hit_pin & sts_sel),
      .wdata(reg_wdata),
      .cfg_o(cfg_w[i]), .status_o(sts_w[i]), .in_o(in_w[i])
    );
    assign en_w[i]  = cfg_w[i].en;
    assign tgt_w[i] = cfg_w[i].tgt;
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (pin_sel == PIN_W'(i))
        reg_rdata = sts_sel ? {6'b0, in_w[i], sts_w[i]} : CFG_W'(cfg_w[i]);
    end
  end

  gpio_irq_route #(.NUM_PINS(NUM_PINS), .NUM_OUT(NUM_OUT)) u_route (
    .clk(clk), .rst_n(rst_n), .en_i(en_w), .sts_i(sts_w), .tgt_i(tgt_w),
    .irq_o(irq_o)
  );
endmodule

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;
  logic       clk = 0, rst_n = 0;
  logic [3:0] pad = '0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we_a = 0, we_b = 0;
  logic [7:0] rdata_a, rdata_b;
  logic [1:0] irq_a, irq_b;
  int checks = 0, errors = 0;
  bit done = 0, model_on = 0;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl #(.NUM_PINS(4), .NUM_OUT(2), .DET_W(2), .ACK_VAL(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .pad_i(pad), .reg_addr(addr), .reg_we(we_a),
    .reg_wdata(wdata), .reg_rdata(rdata_a), .irq_o(irq_a));
  gpio_irq_ctrl #(.NUM_PINS(4), .NUM_OUT(2), .DET_W(1), .ACK_VAL(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .pad_i(pad), .reg_addr(addr), .reg_we(we_b),
    .reg_wdata(wdata), .reg_rdata(rdata_b), .irq_o(irq_b));

  // Bench model of dut, written from the requirements.
  logic [7:0] m_cfg [4];
  logic       m_s1 [4], m_s2 [4], m_pg [4], m_st [4];
  always @(posedge clk) begin : model
    logic g, h;
    for (int i = 0; i < 4; i++) begin
      if (!rst_n) begin
        m_cfg[i] <= 0; m_s1[i] <= 0; m_s2[i] <= 0; m_pg[i] <= 0; m_st[i] <= 0;
      end else begin
        g = m_s2[i] && m_cfg[i][4];
        case (m_cfg[i][3:2])
          2'd0: h = (g == m_cfg[i][1]);
          2'd1: h = g && !m_pg[i];
          2'd2: h = !g && m_pg[i];
          default: h = g ^ m_pg[i];
        endcase
        h = h && m_cfg[i][4];
        if (h) m_st[i] <= 1;
        else if (we_a && addr == {i[1:0], 1'b1} && wdata[0]) m_st[i] <= 0;
        if (we_a && addr == {i[1:0], 1'b0}) m_cfg[i] <= wdata;
        m_pg[i] <= g; m_s2[i] <= m_s1[i]; m_s1[i] <= pad[i];
      end
    end
  end

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    return a[0] ? {6'b0, m_s2[a[2:1]], m_st[a[2:1]]} : m_cfg[a[2:1]];
  endfunction
  function automatic logic [1:0] exp_irq();
    logic [1:0] r = '0;
    for (int i = 0; i < 4; i++)
      if (m_cfg[i][0] && m_st[i] && m_cfg[i][7:5] < 2) r[m_cfg[i][5]] = 1'b1;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask
  task automatic wr(input logic [1:0] p, input logic s, input logic [7:0] d,
                    input logic ea, input logic eb);
    @(negedge clk); addr = {p, s}; wdata = d; we_a = ea; we_b = eb;
    @(negedge clk); we_a = 0; we_b = 0;
  endtask
  task automatic idle(input int n); repeat (n) @(negedge clk); endtask
  task automatic look(input logic [1:0] p, input logic s);
    addr = {p, s}; #1;
  endtask
  task automatic ack_all(input logic [1:0] p);
    wr(p, 1, 8'h01, 1, 1); wr(p, 1, 8'h00, 1, 1);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1; idle(1);
    // R1 reset state
    look(0, 0); chk("R1 cfg", rdata_a, 8'h00);
    look(0, 1); chk("R1 status", rdata_a, 8'h00);
    chk("R1 irq", {6'b0, irq_a}, 8'h00);
    // R12 layout
    wr(1, 0, 8'hFF, 1, 1); look(1, 0);
    chk("R12 a", rdata_a, 8'hFF); chk("R12 b", rdata_b, 8'hF7);
    wr(1, 0, 8'h00, 1, 1);
    // R2 readback latency
    @(negedge clk); pad[0] = 1;
    @(negedge clk); look(0, 1); chk("R2 early", rdata_a, 8'h00);
    @(negedge clk); look(0, 1); chk("R2 seen", rdata_a, 8'h02);
    pad[0] = 0; idle(3);
    // R4/R5 rising, R6 ack polarity
    wr(0, 0, 8'h17, 1, 1); idle(2);
    look(0, 1); chk("R4 quiet", rdata_a, 8'h00); chk("R5 quiet", rdata_b, 8'h00);
    pad[0] = 1; idle(4); look(0, 1);
    chk("R4 rise", rdata_a, 8'h03); chk("R5 rise", rdata_b, 8'h03);
    chk("R10 irq a", {6'b0, irq_a}, 8'h01); chk("R10 irq b", {6'b0, irq_b}, 8'h01);
    wr(0, 1, 8'h01, 1, 1); look(0, 1);
    chk("R6 clear a", rdata_a, 8'h02); chk("R6 ignore b", rdata_b, 8'h03);
    wr(0, 1, 8'h00, 1, 1); look(0, 1);
    chk("R6 clear b", rdata_b, 8'h02); chk("R6 ignore a", rdata_a, 8'h02);
    // R9 mask
    wr(0, 0, 8'h16, 1, 1); pad[0] = 0; idle(3); pad[0] = 1; idle(4);
    look(0, 1); chk("R9 latched", rdata_a, 8'h03);
    chk("R9 masked", {6'b0, irq_a}, 8'h00);
    wr(0, 0, 8'h17, 1, 1); chk("R9 unmask", {6'b0, irq_a}, 8'h01);
    ack_all(0);
    // R10 routing
    wr(2, 0, 8'h37, 1, 1); pad[2] = 1; idle(4);
    chk("R10 tgt1", {6'b0, irq_a}, 8'h02);
    wr(2, 0, 8'hB7, 1, 1); chk("R10 tgt5", {6'b0, irq_a}, 8'h00);
    look(2, 1); chk("R10 pending", rdata_a, 8'h03);
    ack_all(2);
    // R3 level, R11
    pad[3] = 1; wr(3, 0, 8'h13, 1, 1); idle(4); look(3, 1);
    chk("R3 high a", rdata_a, 8'h03); chk("R3 high b", rdata_b, 8'h03);
    wr(3, 1, 8'h01, 1, 0); look(3, 1); chk("R11 reassert", rdata_a, 8'h03);
    pad[3] = 0; idle(4); ack_all(3); look(3, 1); chk("R3 cleared", rdata_a, 8'h00);
    wr(3, 0, 8'h11, 1, 1); idle(2); look(3, 1);
    chk("R3 low a", rdata_a, 8'h01); chk("R3 low b", rdata_b, 8'h01);
    wr(3, 0, 8'h01, 1, 1); ack_all(3); idle(2); look(3, 1);
    chk("R8 gate off", rdata_a, 8'h00);
    // R8 spurious edge on gate raise
    wr(1, 0, 8'h07, 1, 1); pad[1] = 1; idle(4); look(1, 1);
    chk("R8 blocked a", rdata_a, 8'h02); chk("R8 blocked b", rdata_b, 8'h02);
    wr(1, 0, 8'h17, 1, 1); idle(1); look(1, 1);
    chk("R8 spur a", rdata_a, 8'h03); chk("R8 spur b", rdata_b, 8'h03);
    ack_all(1);
    // R4 falling/both, R5 falling
    wr(1, 0, 8'h1B, 1, 0); wr(1, 0, 8'h15, 0, 1);
    pad[1] = 0; idle(4); look(1, 1);
    chk("R4 fall", rdata_a, 8'h01); chk("R5 fall", rdata_b, 8'h01);
    ack_all(1); wr(1, 0, 8'h1F, 1, 0);
    pad[1] = 1; idle(4); look(1, 1);
    chk("R4 both rise", rdata_a, 8'h03); chk("R5 no rise", rdata_b, 8'h02);
    ack_all(1); pad[1] = 0; idle(4); look(1, 1);
    chk("R4 both fall", rdata_a, 8'h01);
    ack_all(1);
    // R7 clear meets edge in the same cycle
    pad[0] = 0; idle(3); ack_all(0);
    @(negedge clk); pad[0] = 1;
    @(negedge clk);
    @(negedge clk); addr = 3'b001; wdata = 8'h01; we_a = 1;
    @(negedge clk); we_a = 0; look(0, 1); chk("R7 set wins", rdata_a, 8'h03);
    wr(0, 1, 8'h01, 1, 0); look(0, 1); chk("R6 later clear", rdata_a, 8'h02);
    // Random phase against the model
    void'($urandom(32'h5EED_1234));
    model_on = 1;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk); we_a = 0;
      pad = pad ^ (4'($urandom) & 4'($urandom));
      case ($urandom % 4)
        0: begin addr = {2'($urandom), 1'b0}; wdata = 8'($urandom); we_a = 1; end
        1: begin addr = {2'($urandom), 1'b1}; wdata = 8'($urandom); we_a = 1; end
        default: begin
          addr = 3'($urandom); #1;
          chk("R4 random read", rdata_a, exp_rd(addr));
          chk("R10 random irq", {6'b0, irq_a}, {6'b0, exp_irq()});
        end
      endcase
    end
    @(negedge clk); we_a = 0;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule